// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two page table entries, one after the other, from an external memory. The ten most significant address bits pick an entry in the root table. That entry, when present, gives the page-aligned base of a second table. The next ten bits pick an entry in that second table, and that entry gives the physical frame. The low twelve bits, the byte offset inside the page, pass straight through.

A client offers an address on a valid/ready request channel. The base of the root table is taken from an input at the moment the request is accepted. The walker then issues one read at a time on a memory read port. That port has its own valid/ready request and a response strobe that may arrive any number of cycles later. The finished translation is held on a valid/ready response channel until the client takes it. If either entry has its present flag clear, the walk ends early with a fault that names the level at which it failed. Only one walk is in flight at any time.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are both 0.
- R2: The first memory read of a walk uses byte address `root_base + 4*va[31:22]`, where `root_base` is the value captured when the request was accepted.
- R3: The second read uses byte address `{pte1[31:12], 12'h000} + 4*va[21:12]`, where `pte1` is the word returned by the first read.
- R4: On a successful walk, `rsp_paddr = {pte2[31:12], va[11:0]}` and `rsp_fault` is 0, where `pte2` is the word returned by the second read.
- R5: If bit 0 (present) of `pte1` is 0, the walk issues no second read. It responds with `rsp_fault`=1, `rsp_fault_lvl`=0 (0 means the root level) and `rsp_paddr`=0.
- R6: If bit 0 of `pte2` is 0, the response has `rsp_fault`=1, `rsp_fault_lvl`=1 (1 means the second level) and `rsp_paddr`=0.
- R7: A successful walk makes exactly two memory reads, in the order root then second level. The second read is not issued before the first read's data has returned, and the response appears only after both reads have returned.
- R8: From request acceptance until the response is taken, `req_ready` stays 0, and a changed `req_vaddr` or `root_base` has no effect on the walk in progress.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay unchanged.
- R10: While `mem_rd_valid`=1 and `mem_rd_ready`=0, `mem_rd_addr` stays unchanged. A read accepted after a stall uses the correct address, and any read latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the root table, captured on acceptance |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 root, 1 second |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word returned |

## Verification
Walks are run with zero read latency and with multi-cycle latency combined with stalls on read acceptance. Comparing the two separates a correct wait-for-data sequence from one that assumes fixed timing or drifts its address while stalled. Root-level and second-level faults are applied to show that the walk stops at the right point and that the fault level is reported correctly. Addresses with all index and offset bits at one and at zero check the bit slicing and the offset pass-through. A request that changes while a walk is in progress, followed by a held-off response, confirms that the captured inputs are isolated and that the output is held steady.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_st_e;

   localparam logic LVL_ROOT   = 1'b0;
   localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/xlate_pte_addr.sv
module xlate_pte_addr #(
   parameter int AW       = 32,
   parameter int IDX_W    = 10,
   parameter int ENT_LOG2 = 2,
   parameter bit ADD_MODE = 1'b1
) (
   input  logic [AW-1:0]    base_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [AW-1:0]    addr_o
);
   localparam int SPAN = IDX_W + ENT_LOG2;

   generate
      if (SPAN >= AW) begin : g_bad_span
         $error("xlate_pte_addr: table span exceeds address width");
      end
      if (ADD_MODE) begin : g_add
         assign addr_o = base_i + {{(AW-SPAN){1'b0}}, idx_i, {ENT_LOG2{1'b0}}};
      end else begin : g_cat
         logic unused_base_low;
         assign unused_base_low = ^base_i[SPAN-1:0];
         assign addr_o = {base_i[AW-1:SPAN], idx_i, {ENT_LOG2{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/xlate_walk_fsm.sv
module xlate_walk_fsm
   import xlate_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     mem_rd_ready,
   input  logic     mem_rsp_valid,
   input  logic     pte_present,
   input  logic     rsp_ready,
   output walk_st_e st_o
);
   walk_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (req_valid)     st_d = ST_L1_REQ;
         ST_L1_REQ:  if (mem_rd_ready)  st_d = ST_L1_WAIT;
         ST_L1_WAIT: if (mem_rsp_valid) st_d = pte_present ? ST_L2_REQ : ST_DONE;
         ST_L2_REQ:  if (mem_rd_ready)  st_d = ST_L2_WAIT;
         ST_L2_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
         ST_DONE:    if (rsp_ready)     st_d = ST_IDLE;
         default:                       st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign st_o = st_q;

   AST_L2_ONLY_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_L2_REQ) |-> ($past(st_q) == ST_L1_WAIT || $past(st_q) == ST_L2_REQ)); // R7

   AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_DONE) |-> $past(mem_rsp_valid)); // R7

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
   import xlate_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PTE_W       = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENT_LOG2    = 2,
   parameter int PRESENT_BIT = 0,
   parameter bit ADD_MODE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  root_base,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic             rsp_fault_lvl,
   output logic             mem_rd_valid,
   input  logic             mem_rd_ready,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data
);
   localparam int L2_LSB  = OFF_W;
   localparam int L1_LSB  = OFF_W + IDX_W;
   localparam int FRAME_W = PA_W - OFF_W;

   generate
      if (VA_W != 2*IDX_W + OFF_W) begin : g_bad_split
         $error("xlate_walker: address split does not cover VA_W");
      end
      if (OFF_W != IDX_W + ENT_LOG2) begin : g_bad_page
         $error("xlate_walker: a table must fill exactly one page");
      end
      if (PTE_W < PA_W || PRESENT_BIT >= OFF_W) begin : g_bad_pte
         $error("xlate_walker: entry layout does not fit");
      end
   endgenerate

   walk_st_e         st;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  base_q;
   logic [PA_W-1:0]  paddr_q;
   logic             fault_q;
   logic             lvl_q;
   logic             pte_present;
   logic [FRAME_W-1:0] pte_frame;
   logic [IDX_W-1:0] idx_sel;
   logic             accept;

   logic unused_pte_bits;
   assign unused_pte_bits = ^mem_rsp_data;

   assign pte_present = mem_rsp_data[PRESENT_BIT];
   assign pte_frame   = mem_rsp_data[PA_W-1:OFF_W];
   assign accept      = (st == ST_IDLE) && req_valid;

   xlate_walk_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .pte_present   (pte_present),
      .rsp_ready     (rsp_ready),
      .st_o          (st)
   );

   assign idx_sel = (st == ST_L1_REQ) ? vaddr_q[L1_LSB +: IDX_W]
                                      : vaddr_q[L2_LSB +: IDX_W];

   xlate_pte_addr #(
      .AW       (PA_W),
      .IDX_W    (IDX_W),
      .ENT_LOG2 (ENT_LOG2),
      .ADD_MODE (ADD_MODE)
   ) u_addr (
      .base_i (base_q),
      .idx_i  (idx_sel),
      .addr_o (mem_rd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vaddr_q <= '0;
         base_q  <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         lvl_q   <= LVL_ROOT;
      end else if (accept) begin
         vaddr_q <= req_vaddr;
         base_q  <= root_base;
         paddr_q <= '0;
         fault_q <= 1'b0;
         lvl_q   <= LVL_ROOT;
      end else if (mem_rsp_valid && st == ST_L1_WAIT) begin
         if (pte_present) base_q <= {pte_frame, {OFF_W{1'b0}}};
         else             fault_q <= 1'b1;
      end else if (mem_rsp_valid && st == ST_L2_WAIT) begin
         lvl_q <= LVL_SECOND;
         if (pte_present) paddr_q <= {pte_frame, vaddr_q[OFF_W-1:0]};
         else             fault_q <= 1'b1;
      end
   end

   assign req_ready     = (st == ST_IDLE);
   assign mem_rd_valid  = (st == ST_L1_REQ) || (st == ST_L2_REQ);
   assign rsp_valid     = (st == ST_DONE);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign rsp_fault_lvl = lvl_q;

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                     && $stable(rsp_fault) && $stable(rsp_fault_lvl))); // R9

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R10

   AST_VADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(vaddr_q)); // R8

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R4

   AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5

endmodule

// File: tb/xlate_walker_tb.sv
module xlate_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] root_base = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        rsp_fault_lvl;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [31:0] pmem [logic [31:0]];
   logic [31:0] rd_log [4];
   int rd_n = 0;
   int cfg_lat = 0;
   int cfg_stall = 0;
   int stall_left = 0;
   int lat_left = 0;
   bit busy = 1'b0;
   logic [31:0] pend_addr = '0;

   always #5 clk = ~clk;

   xlate_walker u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .root_base     (root_base),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_paddr     (rsp_paddr),
      .rsp_fault     (rsp_fault),
      .rsp_fault_lvl (rsp_fault_lvl),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   function automatic logic [31:0] peek(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] l1_addr(input logic [31:0] root, input logic [31:0] va);
      return root + {20'h0, va[31:22], 2'b00};
   endfunction

   function automatic logic [31:0] l2_addr(input logic [31:0] pte1, input logic [31:0] va);
      return {pte1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
   endfunction

   // memory model: acts at falling edges, handshakes land on the next rising edge
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rd_ready  = 1'b0;
      if (busy) begin
         if (lat_left == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = peek(pend_addr);
            busy = 1'b0;
         end else begin
            lat_left--;
         end
      end else if (mem_rd_valid && rst_n) begin
         if (stall_left == 0) begin
            mem_rd_ready = 1'b1;
            pend_addr = mem_rd_addr;
            if (rd_n < 4) rd_log[rd_n] = mem_rd_addr;
            rd_n++;
            busy = 1'b1;
            lat_left = cfg_lat;
            stall_left = cfg_stall;
         end else begin
            stall_left--;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got %h expected %h", what, got, exp);
      end
   endtask

   // one walk: returns after the response has been taken
   task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                           input int lat, input int stall, input int hold, input bit poke,
                           input bit exp_fault, input logic exp_lvl, input logic [31:0] exp_pa,
                           input int exp_rd, input logic [31:0] exp_a0, input logic [31:0] exp_a1);
      bit ready_seen_high;
      logic [31:0] pa0;
      int guard;
      cfg_lat = lat; cfg_stall = stall; stall_left = stall; rd_n = 0;
      ready_seen_high = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; root_base = root;
      guard = 0;
      while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
      @(negedge clk);
      if (poke) begin
         req_vaddr = ~va; root_base = root + 32'h0010_0000;
      end else begin
         req_valid = 1'b0;
      end
      guard = 0;
      while (!rsp_valid && guard < 1000) begin
         if (req_ready) ready_seen_high = 1'b1;
         @(negedge clk); guard++;
      end
      chk(rsp_valid, "R7 response never arrived", {31'h0, rsp_valid}, 32'h1);
      pa0 = rsp_paddr;
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_paddr == pa0, "R9 response not held", rsp_paddr, pa0);
      end
      if (poke)
         chk(!ready_seen_high, "R8 req_ready rose during walk", {31'h0, ready_seen_high}, 32'h0);
      chk(rsp_fault == exp_fault, "R5/R6 fault flag", {31'h0, rsp_fault}, {31'h0, exp_fault});
      if (exp_fault)
         chk(rsp_fault_lvl == exp_lvl, "R5/R6 fault level", {31'h0, rsp_fault_lvl}, {31'h0, exp_lvl});
      chk(rsp_paddr == exp_pa, "R4 physical address", rsp_paddr, exp_pa);
      chk(rd_n == exp_rd, "R7 read count", rd_n, exp_rd);
      if (exp_rd >= 1) chk(rd_log[0] == exp_a0, "R2 root entry address", rd_log[0], exp_a0);
      if (exp_rd >= 2) chk(rd_log[1] == exp_a1, "R3 second entry address", rd_log[1], exp_a1);
      rsp_ready = 1'b1; req_valid = 1'b0;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R8 idle after take", {30'h0, rsp_valid, req_ready}, 32'h1);
   endtask

   // map a page fully and run a walk expecting success
   task automatic ok_walk(input logic [31:0] va, input logic [31:0] root, input logic [31:0] l2base,
                          input logic [31:0] frame, input int lat, input int stall, input int hold,
                          input bit poke);
      logic [31:0] p1, p2;
      p1 = {l2base[31:12], 11'h0, 1'b1};
      p2 = {frame[31:12], 11'h2A5, 1'b1};
      pmem[l1_addr(root, va)] = p1;
      pmem[l2_addr(p1, va)]   = p2;
      run_walk(va, root, lat, stall, hold, poke, 1'b0, 1'b0, {p2[31:12], va[11:0]},
               2, l1_addr(root, va), l2_addr(p1, va));
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
      chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid after reset", {31'h0, mem_rd_valid}, 32'h0);
   endtask

   task automatic t_basic;        // R2 R3 R4 R7
      ok_walk(32'h1234_5678, 32'h0004_0000, 32'h0008_8000, 32'hABCD_E000, 0, 0, 0, 1'b0);
   endtask

   task automatic t_slow_mem;     // R10 R9 with latency and acceptance stalls
      ok_walk(32'h8765_4321, 32'h0004_0000, 32'h0009_1000, 32'h3C3C_3000, 4, 3, 3, 1'b0);
   endtask

   task automatic t_root_fault;   // R5
      logic [31:0] va = 32'h4000_0ABC;
      logic [31:0] root = 32'h0004_0000;
      pmem[l1_addr(root, va)] = 32'hFFFF_F000;   // frame set, present clear
      run_walk(va, root, 2, 1, 0, 1'b0, 1'b1, 1'b0, 32'h0, 1, l1_addr(root, va), 32'h0);
   endtask

   task automatic t_second_fault; // R6
      logic [31:0] va = 32'h0C80_3FFF;
      logic [31:0] root = 32'h0004_0000;
      logic [31:0] p1 = 32'h000A_2001;
      pmem[l1_addr(root, va)] = p1;
      pmem[l2_addr(p1, va)]   = 32'h5555_5FFE;  // present clear
      run_walk(va, root, 1, 0, 0, 1'b0, 1'b1, 1'b1, 32'h0, 2, l1_addr(root, va), l2_addr(p1, va));
   endtask

   task automatic t_ignore_req;   // R8: inputs change mid-walk
      ok_walk(32'h0240_1123, 32'h0004_0000, 32'h000B_3000, 32'h7700_1000, 3, 2, 2, 1'b1);
   endtask

   task automatic t_edges;        // R2 R3 R4 index and offset extremes
      ok_walk(32'hFFFF_FFFF, 32'h0020_0000, 32'h00C0_0000, 32'hFFFF_F000, 0, 0, 0, 1'b0);
      ok_walk(32'h0000_0000, 32'h0020_0000, 32'h00C1_0000, 32'h0000_1000, 1, 0, 0, 1'b0);
   endtask

   task automatic t_back_to_back; // R7 R4 consecutive walks reuse the walker
      ok_walk(32'h3003_0010, 32'h0030_0000, 32'h00D0_0000, 32'h1111_1000, 0, 0, 0, 1'b0);
      ok_walk(32'h3007_0020, 32'h0030_0000, 32'h00D1_0000, 32'h2222_2000, 2, 0, 1, 1'b0);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got %0d expected below 150000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_slow_mem();
      t_root_fault();
      t_second_fault();
      t_ignore_req();
      t_edges();
      t_back_to_back();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule